// File: doc/BRIEF.md
# Parallel-Load Serial-Shift Register with Gated Shift Clock

This block is an eight-stage shift register that runs entirely on a fast system clock. A parallel byte can be copied into all stages, or the contents can be moved one place toward the last stage, where the bit leaves as a serial stream. Software-free glue logic uses it to turn a captured byte into a bit stream, or to chain several registers behind one another through the serial input.

The slow control pins arrive asynchronously. These are the active-low load level and two clock-style inputs. They pass through a two-flop synchronizer. The two clock-style inputs are ORed together, and a 0-to-1 change of that OR, seen in the system-clock domain, counts as one shift. Because of the OR, either input held high acts as an inhibit. The load is a level: while it is low, the stages follow the parallel inputs continuously, and clock activity is ignored. The last stage is driven out both as is and inverted.

The parallel and serial data inputs are sampled without synchronization. They must be held steady from the moment the control pin changes until the stage update three system-clock edges later.

Top module: `par_serial_shifter`

## Requirements
- R1: A synchronous active-high reset with the load inactive clears every stage to 0, so serOut reads 0.
- R2: While shiftLoadN is low, stage i takes parIn[i] (bit 0 is the first stage, bit 7 the last) on every system clock. A change of parIn during a held load is followed.
- R3: While shiftLoadN is low, a rising edge of the combined clock produces no shift. This holds when the edge coincides with the start of the load, and a load in the middle of a shift sequence replaces the partial contents.
- R4: With shiftLoadN high, a 0-to-1 change of (clkInA OR clkInB) shifts once: serIn enters stage 0 and stage k takes the old stage k-1.
- R5: While either clock input stays high, toggling the other causes no shift.
- R6: A rise of clkInB while clkInA is low counts as a shift edge, and the same holds with the roles swapped.
- R7: Without a qualifying rising edge (idle, falling edges, or load released while the OR stays high), all stages hold, and no two shifts occur on consecutive system clocks.
- R8: serOutN is always the inverse of serOut.
- R9: When reset and load are active together, the load wins and the stages take parIn.
- R10: A change on shiftLoadN or a clock input takes effect on the stages at the third system-clock rising edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the stages |
| shiftLoadN | input | 1 | Low: parallel load; high: shift mode (asynchronous) |
| clkInA | input | 1 | Clock-style input A, ORed with B (asynchronous) |
| clkInB | input | 1 | Clock-style input B, ORed with A; usable as inhibit (asynchronous) |
| serIn | input | 1 | Serial data entering stage 0 on a shift |
| parIn | input | 8 | Parallel data, bit i loads stage i |
| serOut | output | 1 | Value of the last stage |
| serOutN | output | 1 | Inverse of the last stage |

## Verification
Two functions can land in the same system cycle: the load level and a rising edge of the combined clock. The same applies to the load and the reset. The bench drives shiftLoadN low in the same step as it raises clkInA from an all-low state, so both pass the synchronizer together. It then expects the stages to hold the parallel byte with no shift applied. For the second pair, it holds the load low while pulsing reset and expects the parallel byte rather than zeros. A reference model in the bench tracks the expected last-stage value across every step, and a load issued partway through shifting out a byte is judged by streaming out the new contents bit by bit.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  // Strobes from control to the stage datapath; at most one is set per cycle
  typedef struct packed {
    logic load;
    logic shift;
  } stage_cmd_t;
endpackage

// File: rtl/shifter_sync.sv
module shifter_sync #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [DEPTH];

  always_ff @(posedge clk) chain[0] <= asyncIn;

  for (genvar i = 1; i < DEPTH; i++) begin : g_flop
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign syncOut = chain[DEPTH-1];
endmodule

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shiftLoadN,
  input  logic       clkInA,
  input  logic       clkInB,
  output stage_cmd_t cmd
);
  localparam int NUM_CTRL = 3;

  logic [NUM_CTRL-1:0] ctrlSync;
  logic ldSync, aSync, bSync;
  logic combNow, combPrev;

  shifter_sync #(.WIDTH(NUM_CTRL), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .asyncIn ({shiftLoadN, clkInA, clkInB}),
    .syncOut (ctrlSync)
  );

  assign {ldSync, aSync, bSync} = ctrlSync;
  assign combNow = aSync | bSync;

  always_ff @(posedge clk) combPrev <= combNow;

  always_comb begin
    cmd.load  = ~ldSync;
    cmd.shift = ldSync & combNow & ~combPrev;
  end

  // R5
  held_high_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ((aSync && $past(aSync)) || (bSync && $past(bSync))) |-> !cmd.shift);

  // R7
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.shift |=> !cmd.shift);
endmodule

// File: rtl/shifter_datapath.sv
module shifter_datapath
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stage_cmd_t       cmd,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] shiftIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_link
    if (i == 0) begin : g_head
      assign shiftIn[i] = serIn;
    end else begin : g_body
      assign shiftIn[i] = stages[i-1];
    end
  end

  // Load outranks reset, reset outranks shift
  always_ff @(posedge clk) begin
    if (cmd.load)       stages <= parIn;
    else if (rst)       stages <= '0;
    else if (cmd.shift) stages <= shiftIn;
  end

  // R2
  load_copies_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> stages == $past(parIn));

  // R4
  shift_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.shift && !cmd.load) |=> stages == {$past(stages[WIDTH-2:0]), $past(serIn)});

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.shift && !cmd.load) |=> $stable(stages));
endmodule

// File: rtl/par_serial_shifter.sv
module par_serial_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftLoadN,
  input  logic             clkInA,
  input  logic             clkInB,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN
);
  stage_cmd_t       cmd;
  logic [WIDTH-1:0] stages;

  shifter_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shiftLoadN (shiftLoadN),
    .clkInA     (clkInA),
    .clkInB     (clkInB),
    .cmd        (cmd)
  );

  shifter_datapath #(.WIDTH(WIDTH)) u_path (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .serIn  (serIn),
    .parIn  (parIn),
    .stages (stages)
  );

  assign serOut  = stages[WIDTH-1];
  assign serOutN = ~stages[WIDTH-1];
endmodule

// File: tb/tb_par_serial_shifter.sv
module tb_par_serial_shifter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, shiftLoadN, clkInA, clkInB, serIn;
  logic [7:0] parIn;
  logic serOut, serOutN;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  logic prevOr = 1'b1;
  bit expQ[$];
  string reqQ[$];
  event sampleNow;

  par_serial_shifter dut (
    .clk(clk), .rst(rst), .shiftLoadN(shiftLoadN), .clkInA(clkInA),
    .clkInB(clkInB), .serIn(serIn), .parIn(parIn),
    .serOut(serOut), .serOutN(serOutN)
  );

  // Monitor: pops the expected last-stage value and compares both outputs
  always @(sampleNow) begin : monitor
    bit e;
    string r;
    e = expQ.pop_front();
    r = reqQ.pop_front();
    checks++;
    if (serOut !== e) begin
      errors++;
      $display("FAIL %s serOut actual %0b expected %0b", r, serOut, e);
    end
    checks++;
    if (serOutN !== ~e) begin
      errors++;
      $display("FAIL R8 (%s) serOutN actual %0b expected %0b", r, serOutN, ~e);
    end
  end

  task automatic expectBit(input bit e, input string r);
    expQ.push_back(e);
    reqQ.push_back(r);
    -> sampleNow;
    #1;
  endtask

  task automatic expectOut(input string r);
    expectBit(model[7], r);
  endtask

  // Driver: applies pins, advances the reference model, waits n negedges
  task automatic drive(input logic ld, input logic a, input logic b,
                       input logic s, input logic [7:0] p, input int n);
    logic newOr;
    shiftLoadN = ld; clkInA = a; clkInB = b; serIn = s; parIn = p;
    newOr = a | b;
    if (!ld) model = p;
    else if (newOr && !prevOr) model = {model[6:0], s};
    prevOr = newOr;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseA(input logic s, input string r);
    drive(1'b1, 1'b1, 1'b0, s, parIn, 4);
    expectOut(r);
    drive(1'b1, 1'b0, 1'b0, s, parIn, 4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [7:0] pat;
    rst = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 6);
    expectOut("R1 initial reset");
    rst = 1'b0;

    // Fill with ones, then reset with load inactive
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 5);
    expectOut("R2 load FF");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 5);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model = 8'h00;
    expectOut("R1 reset clears");
    rst = 1'b0;

    // Load A5, release, fall of OR must not shift
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 5);
    expectOut("R2 load A5");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 5);
    expectOut("R7 hold after release");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 5);
    expectOut("R7 falling edge");

    // Shift out eight bits while feeding 3C
    pat = 8'h3C;
    for (int i = 7; i >= 0; i--) pulseA(pat[i], "R4 shift");

    // Inhibit input rising while the other is low shifts
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 5);
    expectOut("R6 rise on B");
    // B held high: toggling A does nothing
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 4);
      expectOut("R5 A blocked by B");
      drive(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 4);
      expectOut("R5 A blocked by B");
    end
    // A held high: toggling B does nothing
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 4);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 4);
    expectOut("R5 B blocked by A");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 4);
    expectOut("R5 B blocked by A");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 12);
    expectOut("R7 idle hold");

    // Load asserted in the same step as a rising edge
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 5);
    expectOut("R3 load with coincident edge");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 4);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h5A, 4);
    expectOut("R3 edge during load");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 5);
    expectOut("R2 parIn followed while low");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 5);
    expectOut("R7 release with OR high");

    // Load in the middle of a shift sequence
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, 5);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hF0, 5);
    for (int i = 0; i < 3; i++) pulseA(1'b1, "R4 partial shift");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 5);
    expectOut("R3 mid-sequence load");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 5);
    for (int i = 0; i < 8; i++) pulseA(1'b0, "R4 shift after reload");

    // Load has priority over reset
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 5);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expectOut("R9 load beats reset");
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 5);

    // Latency of the load path
    shiftLoadN = 1'b0; parIn = 8'h00;
    repeat (2) @(negedge clk);
    expectBit(1'b1, "R10 load not yet");
    @(negedge clk);
    expectBit(1'b0, "R10 load applied");
    model = 8'h00;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 5);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h40, 5);
    // Latency of the shift path
    clkInA = 1'b1;
    repeat (2) @(negedge clk);
    expectBit(1'b0, "R10 shift not yet");
    @(negedge clk);
    expectBit(1'b1, "R10 shift applied");
    model = 8'h81;
    prevOr = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 5);
    expectOut("R7 hold at end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule